// File: doc/BRIEF.md
# Interruptible Weighted Average Accumulator

This block steps through two lists of 8-bit unsigned values held in memory: one list of samples and one list of weights. For each element it reads one sample and one weight, adds their product into a 32-bit sum-of-products accumulator, and adds the weight into a 16-bit sum-of-weights accumulator. The caller divides the two sums afterwards to form the weighted average. A run begins with a start pulse and three inputs: an element count and the base pointers of the two lists.

The loop is not atomic. In the last cycle of every element the block samples an interrupt request. If a request is pending and elements remain, the block leaves the loop and raises a one-cycle suspended flag. While suspended, its working state is visible on the save outputs: the remaining count, both pointers and both partial sums. Software stores these six bytes of intermediate results together with the pointers. A resume pulse later loads them back through the same count and pointer inputs, plus a restore bus for the sums, and the loop continues from the point where it stopped. The block uses a single read port with one cycle of latency, and each element takes three cycles.

Top module: `wavg_acc`

## Requirements
- R1: During and after reset, busy, done, suspended and mem_rd are 0, and both sums, the save count and both save pointers are 0.
- R2: A start pulse while idle loads elem_cnt, samp_base and wgt_base and clears both sums. busy is 1 from the next cycle until the cycle after done or suspended.
- R3: Each element costs exactly three cycles. In the first cycle mem_rd is 1 with mem_addr equal to the sample pointer. In the second cycle mem_rd is 1 with mem_addr equal to the weight pointer. In the third cycle mem_rd is 0. mem_rdata holds the data one cycle after the request.
- R4: In the third cycle of each element, the sum of products (sop_hi in bits 31:16, sop_lo in bits 15:0) grows by sample times weight modulo 2^32, and sow grows by the weight. With at most 255 elements sow cannot overflow.
- R5: Each element adds 1 to both pointers, wrapping modulo 2^16, and subtracts 1 from the count. The save outputs always show the current count and pointers.
- R6: A start with elem_cnt equal to 0 raises done in the next cycle. No memory read occurs and both sums stay 0.
- R7: done is a single-cycle pulse. It is raised in the cycle after the element that takes the count to 0.
- R8: If irq is 1 in the third cycle of an element and the count left after that element is not 0, suspended pulses for one cycle in the next cycle. No further read is issued, and the save outputs hold the state after that element.
- R9: If an element takes the count to 0, the run ends with done and not suspended, whatever the value of irq.
- R10: A resume pulse while idle loads the count, the pointers and the restore sums, then continues the loop. A suspended run that is resumed with its saved values ends with the same sums as the same run without interruption.
- R11: start and resume are ignored while busy. When both arrive together while idle, start wins and the restore sums are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run |
| resume | input | 1 | Continue a saved run |
| elem_cnt | input | 8 | Element count (start) or remaining count (resume) |
| samp_base | input | 16 | Sample list pointer |
| wgt_base | input | 16 | Weight list pointer |
| restore_sop_hi | input | 16 | Saved sum of products, upper half |
| restore_sop_lo | input | 16 | Saved sum of products, lower half |
| restore_sow | input | 16 | Saved sum of weights |
| irq | input | 1 | Interrupt request, sampled once per element |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Loop active |
| done | output | 1 | One-cycle completion pulse |
| suspended | output | 1 | One-cycle pulse on interrupt exit |
| sop_hi | output | 16 | Sum of products, upper half |
| sop_lo | output | 16 | Sum of products, lower half |
| sow | output | 16 | Sum of weights |
| save_cnt | output | 8 | Remaining count |
| save_samp_ptr | output | 16 | Current sample pointer |
| save_wgt_ptr | output | 16 | Current weight pointer |

## Verification
A bad pointer or count shows up in the next read cycle, as a wrong mem_addr or an extra or missing mem_rd. A bad count can also show as done or suspended arriving in the wrong cycle. A corrupted sum shows on sop_hi, sop_lo or sow in the same cycle, because they are live outputs. A resume that restores state wrongly shows only in the final sums, so the bench compares each resumed run with the same list processed without interruption.

// File: rtl/wavg_pkg.sv
package wavg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SAMP,
      ST_RD_WGT,
      ST_ACCUM,
      ST_FINISH,
      ST_SUSPEND
   } wavg_state_e;
endpackage

// File: rtl/wavg_ctrl.sv
module wavg_ctrl
   import wavg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        resume,
   input  logic        empty_in,
   input  logic        last,
   input  logic        irq,
   output wavg_state_e state,
   output logic        ld_start,
   output logic        ld_resume,
   output logic        step,
   output logic        cap_samp
);
   wavg_state_e state_nx;

   always_comb begin
      ld_start  = (state == ST_IDLE) && start;
      ld_resume = (state == ST_IDLE) && !start && resume;
      step      = (state == ST_ACCUM);
      cap_samp  = (state == ST_RD_WGT);
   end

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: begin
            if (start || resume)
               state_nx = empty_in ? ST_FINISH : ST_RD_SAMP;
         end
         ST_RD_SAMP: state_nx = ST_RD_WGT;
         ST_RD_WGT:  state_nx = ST_ACCUM;
         ST_ACCUM: begin
            if (last)
               state_nx = ST_FINISH;
            else if (irq)
               state_nx = ST_SUSPEND;
            else
               state_nx = ST_RD_SAMP;
         end
         ST_FINISH:  state_nx = ST_IDLE;
         ST_SUSPEND: state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= state_nx;
   end
endmodule

// File: rtl/wavg_addr.sv
module wavg_addr #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic [ADDR_W-1:0] wp_in,
   output logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] wp,
   output logic              last
);
   localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
   localparam logic [ADDR_W-1:0] PTR_INC = ADDR_W'(1);

   assign last = (cnt == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         sp  <= '0;
         wp  <= '0;
      end else if (load) begin
         cnt <= cnt_in;
         sp  <= sp_in;
         wp  <= wp_in;
      end else if (step) begin
         cnt <= cnt - CNT_ONE;
         sp  <= sp + PTR_INC;
         wp  <= wp + PTR_INC;
      end
   end
endmodule

// File: rtl/wavg_mac.sv
module wavg_mac #(
   parameter int DATA_W    = 8,
   parameter int SOP_W     = 32,
   parameter int SOW_W     = 16,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic [SOP_W-1:0]  sop_in,
   input  logic [SOW_W-1:0]  sow_in,
   input  logic              cap_samp,
   input  logic              step,
   input  logic [DATA_W-1:0] rdata,
   output logic [SOP_W-1:0]  sop,
   output logic [SOW_W-1:0]  sow
);
   localparam int PROD_W = 2 * DATA_W;

   logic [DATA_W-1:0] samp_q;
   logic [PROD_W-1:0] prod;

   generate
      if (MUL_ARRAY) begin : g_mul_array
         always_comb begin
            prod = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (rdata[i])
                  prod = prod + (PROD_W'(samp_q) << i);
            end
         end
      end else begin : g_mul_op
         assign prod = PROD_W'(samp_q) * PROD_W'(rdata);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         samp_q <= '0;
      else if (cap_samp)
         samp_q <= rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sop <= '0;
         sow <= '0;
      end else if (ld) begin
         sop <= sop_in;
         sow <= sow_in;
      end else if (step) begin
         sop <= sop + SOP_W'(prod);
         sow <= sow + SOW_W'(rdata);
      end
   end
endmodule

// File: rtl/wavg_acc.sv
module wavg_acc
   import wavg_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SOP_W     = 32,
   parameter int SOW_W     = 16,
   parameter bit MUL_ARRAY = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               resume,
   input  logic [CNT_W-1:0]   elem_cnt,
   input  logic [ADDR_W-1:0]  samp_base,
   input  logic [ADDR_W-1:0]  wgt_base,
   input  logic [SOP_W/2-1:0] restore_sop_hi,
   input  logic [SOP_W/2-1:0] restore_sop_lo,
   input  logic [SOW_W-1:0]   restore_sow,
   input  logic               irq,
   output logic               mem_rd,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               suspended,
   output logic [SOP_W/2-1:0] sop_hi,
   output logic [SOP_W/2-1:0] sop_lo,
   output logic [SOW_W-1:0]   sow,
   output logic [CNT_W-1:0]   save_cnt,
   output logic [ADDR_W-1:0]  save_samp_ptr,
   output logic [ADDR_W-1:0]  save_wgt_ptr
);
   localparam int HALF_W = SOP_W / 2;

   generate
      if (SOP_W % 2 != 0) begin : g_bad_sop_odd
         $error("SOP_W must be even");
      end
      if (SOP_W < 2 * DATA_W) begin : g_bad_sop_w
         $error("SOP_W too narrow for one product");
      end
      if (SOW_W < DATA_W + CNT_W) begin : g_bad_sow_w
         $error("SOW_W may overflow at full count");
      end
   endgenerate

   wavg_state_e      state;
   logic             ld_start, ld_resume, step, cap_samp, last;
   logic [SOP_W-1:0] sop;

   wavg_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .resume    (resume),
      .empty_in  (elem_cnt == '0),
      .last      (last),
      .irq       (irq),
      .state     (state),
      .ld_start  (ld_start),
      .ld_resume (ld_resume),
      .step      (step),
      .cap_samp  (cap_samp)
   );

   wavg_addr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ld_start || ld_resume),
      .step   (step),
      .cnt_in (elem_cnt),
      .sp_in  (samp_base),
      .wp_in  (wgt_base),
      .cnt    (save_cnt),
      .sp     (save_samp_ptr),
      .wp     (save_wgt_ptr),
      .last   (last)
   );

   wavg_mac #(
      .DATA_W(DATA_W), .SOP_W(SOP_W), .SOW_W(SOW_W), .MUL_ARRAY(MUL_ARRAY)
   ) u_mac (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ld_start),
      .ld       (ld_resume),
      .sop_in   ({restore_sop_hi, restore_sop_lo}),
      .sow_in   (restore_sow),
      .cap_samp (cap_samp),
      .step     (step),
      .rdata    (mem_rdata),
      .sop      (sop),
      .sow      (sow)
   );

   always_comb begin
      mem_rd    = (state == ST_RD_SAMP) || (state == ST_RD_WGT);
      mem_addr  = (state == ST_RD_SAMP) ? save_samp_ptr : save_wgt_ptr;
      busy      = (state != ST_IDLE);
      done      = (state == ST_FINISH);
      suspended = (state == ST_SUSPEND);
      sop_hi    = sop[SOP_W-1:HALF_W];
      sop_lo    = sop[HALF_W-1:0];
   end
endmodule

// File: rtl/wavg_acc_chk.sv
module wavg_acc_chk #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 16,
   parameter int SOW_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              suspended,
   input logic              mem_rd,
   input logic [CNT_W-1:0]  save_cnt,
   input logic [ADDR_W-1:0] save_samp_ptr,
   input logic [ADDR_W-1:0] save_wgt_ptr,
   input logic [SOW_W-1:0]  sow
);
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_susp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |=> !suspended);

   a_r9_exclusive_end: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && suspended));

   a_r3_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> mem_rd);

   a_r3_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |=> !mem_rd);

   a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && save_cnt != $past(save_cnt))
         |-> (save_cnt == $past(save_cnt) - CNT_W'(1)));

   a_r5_ptr_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && save_cnt != $past(save_cnt))
         |-> (save_samp_ptr == $past(save_samp_ptr) + ADDR_W'(1)
              && save_wgt_ptr == $past(save_wgt_ptr) + ADDR_W'(1)));

   a_r4_sow_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (sow >= $past(sow)));

   a_r8_no_read_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done || suspended) |-> !mem_rd);
endmodule

bind wavg_acc wavg_acc_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SOW_W(SOW_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .suspended     (suspended),
   .mem_rd        (mem_rd),
   .save_cnt      (save_cnt),
   .save_samp_ptr (save_samp_ptr),
   .save_wgt_ptr  (save_wgt_ptr),
   .sow           (sow)
);

// File: tb/wavg_acc_tb.sv
`timescale 1ns/1ps
module wavg_acc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, resume = 1'b0, irq = 1'b0;
   logic [7:0]  elem_cnt = '0;
   logic [15:0] samp_base = '0, wgt_base = '0;
   logic [15:0] restore_sop_hi = '0, restore_sop_lo = '0, restore_sow = '0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done, suspended;
   logic [15:0] sop_hi, sop_lo, sow;
   logic [7:0]  save_cnt;
   logic [15:0] save_samp_ptr, save_wgt_ptr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit all_ff = 1'b0;

   always #4 clk = ~clk;

   wavg_acc u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
      .elem_cnt(elem_cnt), .samp_base(samp_base), .wgt_base(wgt_base),
      .restore_sop_hi(restore_sop_hi), .restore_sop_lo(restore_sop_lo),
      .restore_sow(restore_sow), .irq(irq), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .suspended(suspended), .sop_hi(sop_hi), .sop_lo(sop_lo), .sow(sow),
      .save_cnt(save_cnt), .save_samp_ptr(save_samp_ptr),
      .save_wgt_ptr(save_wgt_ptr)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      if (all_ff) return 8'hFF;
      return a[7:0] * 8'd37 + a[15:8] + 8'd11;
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

   function automatic logic [31:0] ref_sop(input int n, input logic [15:0] s, input logic [15:0] w, input logic [31:0] init);
      logic [31:0] acc = init;
      for (int i = 0; i < n; i++) acc = acc + memf(s + 16'(i)) * memf(w + 16'(i));
      return acc;
   endfunction

   function automatic logic [15:0] ref_sow(input int n, input logic [15:0] w, input logic [15:0] init);
      logic [15:0] acc = init;
      for (int i = 0; i < n; i++) acc = acc + 16'(memf(w + 16'(i)));
      return acc;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 sample read, 2 weight read,
   // 3 accumulate, 4 done, 5 suspended
   int          m_ph = 0;
   logic [7:0]  m_cnt = '0, m_s = '0;
   logic [15:0] m_sp = '0, m_wp = '0, m_sow = '0;
   logic [31:0] m_sop = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = '0; m_sp = '0; m_wp = '0; m_sop = '0; m_sow = '0;
      end else begin
         case (m_ph)
            0: if (start || resume) begin
                  m_cnt = elem_cnt; m_sp = samp_base; m_wp = wgt_base;
                  if (start) begin m_sop = '0; m_sow = '0; end
                  else begin m_sop = {restore_sop_hi, restore_sop_lo}; m_sow = restore_sow; end
                  m_ph = (elem_cnt == 0) ? 4 : 1;
               end
            1: m_ph = 2;
            2: begin m_s = memf(m_sp); m_ph = 3; end
            3: begin
                  m_sop = m_sop + m_s * memf(m_wp);
                  m_sow = m_sow + 16'(memf(m_wp));
                  m_sp++; m_wp++; m_cnt--;
                  m_ph = (m_cnt == 0) ? 4 : (irq ? 5 : 1);
               end
            default: m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(mem_rd == (m_ph == 1 || m_ph == 2), "R3 mem_rd", mem_rd, (m_ph == 1 || m_ph == 2));
         if (m_ph == 1) chk(mem_addr == m_sp, "R3 sample addr", mem_addr, m_sp);
         if (m_ph == 2) chk(mem_addr == m_wp, "R3 weight addr", mem_addr, m_wp);
         chk({sop_hi, sop_lo} == m_sop, "R4 sop", {sop_hi, sop_lo}, m_sop);
         chk(sow == m_sow, "R4 sow", sow, m_sow);
         chk(save_cnt == m_cnt, "R5 count", save_cnt, m_cnt);
         chk(save_samp_ptr == m_sp && save_wgt_ptr == m_wp, "R5 pointers",
             {save_samp_ptr, save_wgt_ptr}, {m_sp, m_wp});
         chk(busy == (m_ph != 0), "R2 busy", busy, (m_ph != 0));
         chk(done == (m_ph == 4), "R7 done", done, (m_ph == 4));
         chk(suspended == (m_ph == 5), "R8 suspended", suspended, (m_ph == 5));
      end
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic launch(input bit is_start, input bit is_resume, input logic [7:0] n,
                         input logic [15:0] s, input logic [15:0] w,
                         input logic [31:0] rs, input logic [15:0] rw);
      @(negedge clk);
      elem_cnt = n; samp_base = s; wgt_base = w;
      restore_sop_hi = rs[31:16]; restore_sop_lo = rs[15:0]; restore_sow = rw;
      start = is_start; resume = is_resume;
      @(negedge clk);
      start = 1'b0; resume = 1'b0;
   endtask

   task automatic wait_end(output bit was_done);
      int guard = 0;
      while (!(done || suspended) && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      was_done = done;
   endtask

   initial begin
      bit fin;
      logic [7:0]  sv_cnt;
      logic [15:0] sv_sp, sv_wp, sv_sow;
      logic [31:0] sv_sop;

      repeat (3) @(negedge clk);
      chk(!busy && !done && !suspended && !mem_rd, "R1 reset flags", {busy, done, suspended, mem_rd}, 0);
      chk({sop_hi, sop_lo, sow} == '0 && save_cnt == 0 && save_samp_ptr == 0 && save_wgt_ptr == 0,
          "R1 reset state", {sop_hi, sop_lo, sow}, 0);
      rst_n = 1'b1;

      // R2/R4: plain run of five elements
      launch(1, 0, 8'd5, 16'h0010, 16'h0080, 32'h0, 16'h0);
      wait_end(fin);
      chk(fin, "R7 run ends in done", fin, 1);
      chk({sop_hi, sop_lo} == ref_sop(5, 16'h0010, 16'h0080, 0), "R4 final sop",
          {sop_hi, sop_lo}, ref_sop(5, 16'h0010, 16'h0080, 0));
      chk(sow == ref_sow(5, 16'h0080, 0), "R4 final sow", sow, ref_sow(5, 16'h0080, 0));

      // R6: empty list
      launch(1, 0, 8'd0, 16'h1234, 16'h4321, 32'h0, 16'h0);
      chk(done, "R6 done in next cycle", done, 1);
      chk({sop_hi, sop_lo, sow} == '0, "R6 sums zero", {sop_hi, sop_lo, sow}, 0);

      // R5: pointer wrap
      launch(1, 0, 8'd4, 16'hFFFE, 16'h7FFF, 32'h0, 16'h0);
      wait_end(fin);
      chk(save_samp_ptr == 16'h0002, "R5 sample pointer wraps", save_samp_ptr, 16'h0002);
      chk(save_wgt_ptr == 16'h8003, "R5 weight pointer", save_wgt_ptr, 16'h8003);

      // R8/R10: suspend after first element, then resume
      irq = 1'b1;
      launch(1, 0, 8'd6, 16'h0100, 16'h0200, 32'h0, 16'h0);
      wait_end(fin);
      chk(!fin && suspended, "R8 suspended exit", suspended, 1);
      chk(save_cnt == 8'd5, "R8 saved count", save_cnt, 5);
      sv_cnt = save_cnt; sv_sp = save_samp_ptr; sv_wp = save_wgt_ptr;
      sv_sop = {sop_hi, sop_lo}; sv_sow = sow;
      irq = 1'b0;
      repeat (4) @(negedge clk);
      chk(!mem_rd && !busy, "R8 no reads while suspended", mem_rd, 0);
      launch(0, 1, sv_cnt, sv_sp, sv_wp, sv_sop, sv_sow);
      wait_end(fin);
      chk(fin, "R10 resumed run completes", fin, 1);
      chk({sop_hi, sop_lo} == ref_sop(6, 16'h0100, 16'h0200, 0), "R10 sop matches",
          {sop_hi, sop_lo}, ref_sop(6, 16'h0100, 16'h0200, 0));
      chk(sow == ref_sow(6, 16'h0200, 0), "R10 sow matches", sow, ref_sow(6, 16'h0200, 0));

      // R9: irq on final element
      irq = 1'b1;
      launch(1, 0, 8'd1, 16'h0300, 16'h0400, 32'h0, 16'h0);
      wait_end(fin);
      chk(fin && !suspended, "R9 done wins over irq", fin, 1);
      irq = 1'b0;

      // R11: start while busy ignored
      launch(1, 0, 8'd5, 16'h0500, 16'h0600, 32'h0, 16'h0);
      repeat (3) @(negedge clk);
      launch(1, 0, 8'd9, 16'h0700, 16'h0800, 32'h0, 16'h0);
      wait_end(fin);
      chk({sop_hi, sop_lo} == ref_sop(5, 16'h0500, 16'h0600, 0), "R11 busy start ignored",
          {sop_hi, sop_lo}, ref_sop(5, 16'h0500, 16'h0600, 0));

      // R11: start beats resume
      launch(1, 1, 8'd2, 16'h0900, 16'h0A00, 32'h1234_5678, 16'h0777);
      wait_end(fin);
      chk(sow == ref_sow(2, 16'h0A00, 0), "R11 start priority", sow, ref_sow(2, 16'h0A00, 0));

      // R4: sum of products wraps modulo 2^32
      launch(0, 1, 8'd1, 16'h0B00, 16'h0C00, 32'hFFFF_FFF0, 16'h0010);
      wait_end(fin);
      chk({sop_hi, sop_lo} == ref_sop(1, 16'h0B00, 16'h0C00, 32'hFFFF_FFF0), "R4 sop wraps",
          {sop_hi, sop_lo}, ref_sop(1, 16'h0B00, 16'h0C00, 32'hFFFF_FFF0));

      // R4: full count with maximum values
      all_ff = 1'b1;
      launch(1, 0, 8'd255, 16'h0000, 16'h4000, 32'h0, 16'h0);
      wait_end(fin);
      chk(sow == 16'd65025, "R4 sow at full count", sow, 65025);
      chk({sop_hi, sop_lo} == 32'd16581375, "R4 sop at full count", {sop_hi, sop_lo}, 16581375);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule